// File: doc/BRIEF.md
# Dual-Output Carrier Modulator for a Three-Leg Nine-Switch Bridge

This block drives the nine switches of a three-leg bridge that feeds two independent three-phase outputs. Each leg has a top switch, a middle switch and a bottom switch. The block receives three signed reference samples for the top output and three for the bottom output. It also receives a modulation index for each output and an extra shoot-through ratio for each output, all in Q1.14 fixed point. For each output it computes one common offset. It adds that offset to the output's references, saturating the sum. It then compares the shifted values against a single shared triangular carrier.

The top output's offset is built from the minimum of its references. The bottom output's offset is built from the maximum of its references. This pins the lowest shifted top reference and the highest shifted bottom reference at a fixed level, so the shoot-through interval of each output stays the same in every carrier period. The top gate and the bottom gate of each leg come from the two comparisons. The middle gate is the exclusive-OR of those two. A per-leg clamp keeps the bottom compare value from rising above the top compare value, so no leg can reach the state with all three switches off. All inputs are taken only when the carrier sits at its positive peak, so a compare value never moves within a half period.

Top module: `nsw_carrier_mod`

## Requirements
- R1: The carrier is a signed 16-bit count that is -16384 after reset and rises first. It moves by CAR_STEP every cycle and reverses on reaching +16384 or -16384, so one carrier period lasts 65536/CAR_STEP cycles.
- R2: References, indices and ratios are taken only in the cycle where the carrier equals +16384. The new compare values act from the following cycle. Input changes at any other time have no effect on the gates.
- R3: The top offset is 16384 - min(top refs) - k(m_up) - 2*tex_lo, where k(m) = (m*28378) arithmetically shifted right by 14.
- R4: The bottom offset is -16384 - max(bottom refs) + k(m_lo) - 2*tex_up, with k as in R3.
- R5: If a leg's shifted bottom value exceeds its shifted top value, the bottom value is replaced by the top value. As a result, at least one of that leg's top and bottom gates is on in every cycle.
- R6: Bit j of gate_up is on when leg j's top compare value is at or above the carrier. Bit j of gate_lo is on when the carrier is at or above leg j's bottom compare value.
- R7: Bit j of gate_mid equals gate_up[j] XOR gate_lo[j].
- R8: During reset and until the first load, both compare values of every leg hold +32767. Every leg therefore shows gate_up=1, gate_lo=0 and gate_mid=1, and the carrier shows -16384.
- R9: Each reference-plus-offset sum saturates to the range -32768..+32767 before the clamp and the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_up | input | 48 | Top-output references, Q1.14, leg j in bits [16j+15:16j] |
| ref_lo | input | 48 | Bottom-output references, Q1.14, same packing |
| m_up | input | 16 | Top-output modulation index, Q1.14 |
| m_lo | input | 16 | Bottom-output modulation index, Q1.14 |
| tex_up | input | 16 | Extra shoot-through ratio for the top output, Q1.14 |
| tex_lo | input | 16 | Extra shoot-through ratio for the bottom output, Q1.14 |
| carrier | output | 16 | Current carrier value, Q1.14 |
| gate_up | output | 3 | Top switch gates, bit j for leg j |
| gate_lo | output | 3 | Bottom switch gates |
| gate_mid | output | 3 | Middle switch gates |

## Verification
The bench builds the block with CAR_STEP = 1024, which gives a 64-cycle carrier period. Many reference patterns, each lasting several periods, therefore fit in a short run. Every carrier value is a multiple of 1024. References placed on that grid make the compare-equals-carrier ties of R6 occur exactly. The chosen patterns reach both saturation limits of R9 and the bottom-above-top case of R5. Some input changes fall in the middle of a half period, which exercises R2.

// File: rtl/nsw_pkg.sv
package nsw_pkg;
    localparam int DW   = 16;
    localparam int FRAC = 14;
    localparam int WW   = 24;

    typedef logic signed [DW-1:0] q_t;
    typedef logic signed [WW-1:0] w_t;

    localparam q_t Q_ONE   = q_t'(16384);
    localparam q_t Q_MAX   = q_t'(32767);
    localparam q_t Q_MIN   = q_t'(-32768);
    localparam int ROOT3_Q = 28378;

    typedef struct packed {
        q_t hi;
        q_t lo;
    } cmp_pair_t;

    function automatic q_t sat_q(input w_t v);
        if (v > w_t'(Q_MAX))      return Q_MAX;
        else if (v < w_t'(Q_MIN)) return Q_MIN;
        else                      return q_t'(v);
    endfunction

    function automatic w_t root3_scale(input q_t m);
        logic signed [31:0] prod;
        prod = 32'(m) * 32'sd28378;
        return w_t'(prod >>> FRAC);
    endfunction
endpackage

// File: rtl/nsw_carrier.sv
module nsw_carrier
    import nsw_pkg::*;
#(
    parameter int CAR_STEP = 1
) (
    input  logic clk,
    input  logic rst,
    output q_t   car,
    output logic at_peak
);
    localparam q_t STEP_Q = q_t'(CAR_STEP);

    q_t   cnt_q;
    logic rising_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= -Q_ONE;
            rising_q <= 1'b1;
        end else if (rising_q) begin
            if (cnt_q >= Q_ONE - STEP_Q) begin
                cnt_q    <= Q_ONE;
                rising_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + STEP_Q;
            end
        end else begin
            if (cnt_q <= -Q_ONE + STEP_Q) begin
                cnt_q    <= -Q_ONE;
                rising_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - STEP_Q;
            end
        end
    end

    assign car     = cnt_q;
    assign at_peak = (cnt_q == Q_ONE);

    // R1
    car_range_chk: assert property (@(posedge clk) disable iff (rst)
        (car <= Q_ONE) && (car >= -Q_ONE));
    // R1
    car_peak_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (car == Q_ONE) |=> (car == Q_ONE - STEP_Q));
    // R1
    car_valley_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (car == -Q_ONE) |=> (car == -Q_ONE + STEP_Q));
endmodule

// File: rtl/nsw_offset.sv
module nsw_offset
    import nsw_pkg::*;
#(
    parameter int  N_LEGS   = 3,
    parameter bit  IS_UPPER = 1'b1
) (
    input  q_t refs    [N_LEGS],
    input  q_t m_idx,
    input  q_t tex_oth,
    output q_t shifted [N_LEGS]
);
    q_t ext;
    w_t offs;

    always_comb begin
        ext = refs[0];
        for (int j = 1; j < N_LEGS; j++) begin
            if (IS_UPPER) begin
                if (refs[j] < ext) ext = refs[j];
            end else begin
                if (refs[j] > ext) ext = refs[j];
            end
        end
    end

    generate
        if (IS_UPPER) begin : g_top
            // R3
            assign offs = w_t'(Q_ONE) - w_t'(ext) - root3_scale(m_idx)
                          - (w_t'(tex_oth) <<< 1);
        end else begin : g_bot
            // R4
            assign offs = -w_t'(Q_ONE) - w_t'(ext) + root3_scale(m_idx)
                          - (w_t'(tex_oth) <<< 1);
        end
    endgenerate

    // R9
    always_comb begin
        for (int j = 0; j < N_LEGS; j++) begin
            shifted[j] = sat_q(w_t'(refs[j]) + offs);
        end
    end
endmodule

// File: rtl/nsw_leg.sv
module nsw_leg
    import nsw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  q_t   top_in,
    input  q_t   bot_in,
    input  q_t   car,
    output logic g_top,
    output logic g_bot,
    output logic g_mid
);
    cmp_pair_t cmp_q;
    q_t        bot_lim;

    // R5
    assign bot_lim = (bot_in > top_in) ? top_in : bot_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q.hi <= Q_MAX;
            cmp_q.lo <= Q_MAX;
        end else if (load) begin
            cmp_q.hi <= top_in;
            cmp_q.lo <= bot_lim;
        end
    end

    // R6
    assign g_top = (cmp_q.hi >= car);
    assign g_bot = (car >= cmp_q.lo);
    // R7
    assign g_mid = g_top ^ g_bot;

    // R2
    cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cmp_q));
    // R5
    cmp_order_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_q.lo <= cmp_q.hi);
    // R5
    leg_not_open_chk: assert property (@(posedge clk) disable iff (rst)
        g_top || g_bot);
endmodule

// File: rtl/nsw_carrier_mod.sv
module nsw_carrier_mod
    import nsw_pkg::*;
#(
    parameter int CAR_STEP = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [47:0] ref_up,
    input  logic [47:0] ref_lo,
    input  logic [15:0] m_up,
    input  logic [15:0] m_lo,
    input  logic [15:0] tex_up,
    input  logic [15:0] tex_lo,
    output logic [15:0] carrier,
    output logic [2:0]  gate_up,
    output logic [2:0]  gate_lo,
    output logic [2:0]  gate_mid
);
    localparam int N_LEGS = 3;

    q_t   car;
    logic at_peak;
    q_t   top_refs [N_LEGS];
    q_t   bot_refs [N_LEGS];
    q_t   top_sh   [N_LEGS];
    q_t   bot_sh   [N_LEGS];

    nsw_carrier #(.CAR_STEP(CAR_STEP)) u_car (
        .clk(clk), .rst(rst), .car(car), .at_peak(at_peak)
    );

    generate
        for (genvar j = 0; j < N_LEGS; j++) begin : g_unpack
            assign top_refs[j] = q_t'(ref_up[j*DW +: DW]);
            assign bot_refs[j] = q_t'(ref_lo[j*DW +: DW]);
        end
    endgenerate

    nsw_offset #(.N_LEGS(N_LEGS), .IS_UPPER(1'b1)) u_off_top (
        .refs(top_refs), .m_idx(q_t'(m_up)), .tex_oth(q_t'(tex_lo)),
        .shifted(top_sh)
    );

    nsw_offset #(.N_LEGS(N_LEGS), .IS_UPPER(1'b0)) u_off_bot (
        .refs(bot_refs), .m_idx(q_t'(m_lo)), .tex_oth(q_t'(tex_up)),
        .shifted(bot_sh)
    );

    generate
        for (genvar j = 0; j < N_LEGS; j++) begin : g_leg
            nsw_leg u_leg (
                .clk(clk), .rst(rst), .load(at_peak),
                .top_in(top_sh[j]), .bot_in(bot_sh[j]), .car(car),
                .g_top(gate_up[j]), .g_bot(gate_lo[j]), .g_mid(gate_mid[j])
            );
        end
    endgenerate

    assign carrier = car;
endmodule

// File: tb/tb_nsw_carrier_mod.sv
module tb_nsw_carrier_mod;
    localparam int STEP = 1024;
    localparam int ONE  = 16384;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic signed [15:0] ru [3];
    logic signed [15:0] rl [3];
    logic signed [15:0] mu, ml, txu, txl;
    logic [15:0] carrier;
    logic [2:0]  gate_up, gate_lo, gate_mid;

    nsw_carrier_mod #(.CAR_STEP(STEP)) dut (
        .clk(clk), .rst(rst),
        .ref_up({ru[2], ru[1], ru[0]}), .ref_lo({rl[2], rl[1], rl[0]}),
        .m_up(mu), .m_lo(ml), .tex_up(txu), .tex_lo(txl),
        .carrier(carrier), .gate_up(gate_up), .gate_lo(gate_lo),
        .gate_mid(gate_mid)
    );

    typedef struct {
        int         car;
        logic [2:0] up;
        logic [2:0] lo;
        logic [2:0] mid;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit started = 0;
    int m_cnt, m_dir;
    int cu [3];
    int cl [3];

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int kr3(input int m);
        return (m * 28378) >>> 14;
    endfunction

    // bench model built from R1 R2 R3 R4 R5 R8 R9
    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_cnt = -ONE;
            m_dir = 1;
            for (int j = 0; j < 3; j++) begin cu[j] = 32767; cl[j] = 32767; end
        end else begin
            if (m_cnt == ONE) begin
                int mn, mx, ou, ol;
                mn = ru[0]; mx = rl[0];
                for (int j = 1; j < 3; j++) begin
                    if (ru[j] < mn) mn = ru[j];
                    if (rl[j] > mx) mx = rl[j];
                end
                ou = ONE - mn - kr3(mu) - 2 * txl;
                ol = -ONE - mx + kr3(ml) - 2 * txu;
                for (int j = 0; j < 3; j++) begin
                    cu[j] = sat16(ru[j] + ou);
                    cl[j] = sat16(rl[j] + ol);
                    if (cl[j] > cu[j]) cl[j] = cu[j];
                end
            end
            if (m_dir == 1) begin
                m_cnt = m_cnt + STEP;
                if (m_cnt >= ONE) begin m_cnt = ONE; m_dir = 0; end
            end else begin
                m_cnt = m_cnt - STEP;
                if (m_cnt <= -ONE) begin m_cnt = -ONE; m_dir = 1; end
            end
        end
    end

    // driver side of the scoreboard: expected item per cycle
    always @(negedge clk) begin
        if (started) begin
            exp_t e;
            e.car = m_cnt;
            for (int j = 0; j < 3; j++) begin
                e.up[j]  = (cu[j] >= m_cnt);   // R6
                e.lo[j]  = (m_cnt >= cl[j]);   // R6
                e.mid[j] = e.up[j] ^ e.lo[j];  // R7
            end
            q.push_back(e);
        end
    end

    // monitor side: pop and compare
    always @(negedge clk) begin
        if (started) begin
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if ($signed(carrier) != e.car) begin
                    bad++;
                    $display("FAIL R1 carrier actual=%0d expected=%0d", $signed(carrier), e.car);
                end
                total++;
                if (gate_up != e.up) begin
                    bad++;
                    $display("FAIL R6 top gates (offset per R3) actual=%b expected=%b", gate_up, e.up);
                end
                total++;
                if (gate_lo != e.lo) begin
                    bad++;
                    $display("FAIL R6 bottom gates (offset per R4) actual=%b expected=%b", gate_lo, e.lo);
                end
                total++;
                if (gate_mid != e.mid) begin
                    bad++;
                    $display("FAIL R7 mid gates actual=%b expected=%b", gate_mid, e.mid);
                end
                total++;
                if ((gate_up | gate_lo) != 3'b111) begin
                    bad++;
                    $display("FAIL R5 open leg actual=%b expected=111", gate_up | gate_lo);
                end
            end
        end
    end

    task automatic drive(input int a0, input int a1, input int a2,
                         input int b0, input int b1, input int b2,
                         input int pm_u, input int pm_l, input int pt_u, input int pt_l,
                         input int cycles);
        ru[0] = 16'(a0); ru[1] = 16'(a1); ru[2] = 16'(a2);
        rl[0] = 16'(b0); rl[1] = 16'(b1); rl[2] = 16'(b2);
        mu = 16'(pm_u); ml = 16'(pm_l); txu = 16'(pt_u); txl = 16'(pt_l);
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        // R8 reset state
        total++;
        if (gate_up != 3'b111 || gate_lo != 3'b000 || gate_mid != 3'b111 ||
            $signed(carrier) != -ONE) begin
            bad++;
            $display("FAIL R8 reset actual=%b/%b/%b car=%0d expected=111/000/111 car=-16384",
                     gate_up, gate_lo, gate_mid, $signed(carrier));
        end
        rst = 1'b0;
        // R8 state holds before first peak
        repeat (10) @(negedge clk);
        // R3 R4 balanced sets, both outputs active
        drive(8192, -4096, -4096, 4096, -2048, -2048, 8192, 8192, 0, 0, 200);
        // R2 change in mid half period (not a peak-aligned moment)
        drive(4096, 0, -4096, -4096, 0, 4096, 6144, 4096, 0, 0, 37);
        drive(12288, -8192, 0, 2048, 2048, -4096, 6144, 4096, 1024, 2048, 150);
        // R3 R4 extra shoot-through ratios, grid-aligned ties for R6
        drive(0, 1024, -1024, 0, -1024, 1024, 4096, 4096, 2048, 1024, 200);
        // R5 bottom set driven above top set
        drive(-8192, -8192, -8192, 8192, 8192, 8192, 0, 16384, 0, 0, 200);
        // R9 positive saturation of top sums
        drive(30000, -30000, 0, 0, 0, 0, 0, 0, 0, 0, 200);
        // R9 negative saturation of bottom sums
        drive(0, 0, 0, -30000, 30000, 0, 16384, 16384, -4096, -4096, 200);
        // R1 long run on a steady pattern
        drive(2048, -2048, 0, -2048, 2048, 0, 8192, 12288, 512, 512, 400);
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule